// File: doc/BRIEF.md
# Serial Port Register Front End with Banked Divisor

This block is the processor-facing register file of a 16550-style serial port. A host reaches it over a small byte bus: a 3-bit offset, separate read and write strobes, and 8-bit write and read data. The block decodes each access to one of twelve logical registers. It holds the configuration registers: interrupt enable, line control, modem control, FIFO control, scratch, and a 16-bit baud divisor. It also builds the status and identification bytes from live inputs supplied by a separate serial core. That core owns the shift registers, the FIFOs and the baud generator.

The same offset can reach different registers. Which one depends on the direction of the access and on a bank bit, which is the top bit of the line control register. With the bank bit set, offsets 0 and 1 reach the two bytes of the divisor. With it clear, offset 0 reaches the receive data on reads and the transmit holding register on writes, and offset 1 reaches the interrupt enable register.

A three-state access tracker remembers the kind of the last access: `ACC_IDLE`, `ACC_READ` or `ACC_WRITE`. The next state is `ACC_WRITE` whenever the write strobe is high. It is `ACC_READ` when only the read strobe is high, and `ACC_IDLE` otherwise. Every state can move to every other state. The core-facing strobes are decoded from this state and from the register selected in that access, so each strobe lasts exactly one cycle per access.

Top module: `uart_regfile`

## Requirements
- R1: After reset, the interrupt enable register, line control register, modem control register, FIFO control register, scratch register, the 16-bit divisor output and `rdata` are all 0, and neither `tx_strobe` nor `rx_pop` is asserted.
- R2: With the bank bit (bit 7 of `lcr_cfg`) at 0, a write to offset 0 loads `tx_byte` and raises `tx_strobe` for exactly the one cycle after the write edge. A write to offset 1 stores the interrupt enable register. Reading offset 1 then returns the written value ANDed with 0x0F, and `ier_cfg` shows the same value.
- R3: With the bank bit at 1, offsets 0 and 1 read and write the low and high divisor bytes, so that `divisor` = {high, low}. Such a write neither strobes `tx_strobe` nor changes the interrupt enable register. `divisor` changes only on a write.
- R4: A read of offset 0 with the bank bit at 0 returns `rx_byte` on `rdata` and raises `rx_pop` for exactly the one cycle after the read edge. A read of any other offset, or of offset 0 with the bank bit at 1, produces no `rx_pop`.
- R5: A read of offset 5 returns line status with these bit positions: bit 0 `rx_ready`, bit 1 overrun, bit 2 parity error, bit 3 framing error, bit 4 break, bit 5 `tx_hold_empty`, bit 6 `tx_empty`, bit 7 `rx_fifo_err`.
- R6: The overrun, parity, framing and break bits are sticky. A pulse on the matching input is held until the next line status read, which returns it and then clears it. Bits 0, 5, 6 and 7 follow their inputs live.
- R7: A read of offset 2 returns the interrupt identification byte. Bits 3:0 hold the highest-priority enabled source: 0x6 for a line status error (IER bit 2 and any of line status bits 4:1 set), 0x4 for received data (IER bit 0 and `rx_ready`), 0x2 for transmit holding empty (IER bit 1 and `tx_hold_empty`), 0x0 for a modem change (IER bit 3 and any of `modem_stat` bits 3:0), and 0x1 when no source is active. Bits 7:6 both equal bit 0 of the FIFO control register, and bits 5:4 are 0. A write to offset 2 loads `fcr_cfg`.
- R8: Offsets 3, 4 and 7 read back the last value written to them in full (line control, modem control and scratch). Offset 6 returns `modem_stat`.
- R9: Writes to offsets 5 and 6 are ignored. They change no register and no output.
- R10: When the read and write strobes are high in the same cycle, only the write takes effect: `rdata` keeps its value and no `rx_pop` occurs.
- R11: `rdata` is registered. It updates on the edge of a read and holds its value in every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| rx_byte | input | 8 | Head byte of the receive queue in the serial core |
| rx_ready | input | 1 | Receive queue not empty |
| rx_overrun | input | 1 | Overrun event |
| rx_parity_err | input | 1 | Parity error event |
| rx_frame_err | input | 1 | Framing error event |
| rx_break | input | 1 | Break event |
| tx_hold_empty | input | 1 | Transmit holding space free |
| tx_empty | input | 1 | Transmitter fully idle |
| rx_fifo_err | input | 1 | Error present in the receive queue |
| modem_stat | input | 8 | Modem status byte |
| tx_strobe | output | 1 | One-cycle send request |
| tx_byte | output | 8 | Byte to send |
| rx_pop | output | 1 | One-cycle receive dequeue |
| ier_cfg | output | 4 | Interrupt enable bits |
| lcr_cfg | output | 8 | Line control register |
| mcr_cfg | output | 8 | Modem control register |
| fcr_cfg | output | 8 | FIFO control register |
| divisor | output | 16 | Baud divisor |

## Verification
If the bank bit is latched wrongly or lost, the next access to offset 0 or 1 goes to the wrong bank. That shows up in the following cycle as a missing or extra `tx_strobe` or `rx_pop`, or as a divisor that does not move. If the sticky error state is wrong, it stays hidden until the next line status or identification read, which then returns a wrong bit. The same happens if the state is not cleared on a read, in which case the second of two back-to-back reads shows it. The sweeps cover every byte through the scratch and divisor paths, every enable mask against every status combination for the identification priority, and each line status bit on its own.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 8;
    localparam int EVT_W  = 4;

    localparam logic [ADDR_W-1:0] OFF_DATA = 3'd0;
    localparam logic [ADDR_W-1:0] OFF_IEN  = 3'd1;
    localparam logic [ADDR_W-1:0] OFF_ID   = 3'd2;
    localparam logic [ADDR_W-1:0] OFF_LINE = 3'd3;
    localparam logic [ADDR_W-1:0] OFF_MDMC = 3'd4;
    localparam logic [ADDR_W-1:0] OFF_LSTA = 3'd5;
    localparam logic [ADDR_W-1:0] OFF_MSTA = 3'd6;
    localparam logic [ADDR_W-1:0] OFF_SCR  = 3'd7;

    typedef enum logic [3:0] {
        SEL_NONE, SEL_RBR, SEL_THR, SEL_IER, SEL_IIR, SEL_FCR, SEL_LCR,
        SEL_MCR, SEL_LSR, SEL_MSR, SEL_SCR, SEL_DLL, SEL_DLM
    } reg_sel_e;

    typedef enum logic [1:0] {
        ACC_IDLE, ACC_READ, ACC_WRITE
    } acc_state_e;
endpackage

// File: rtl/uart_rf_decode.sv
module uart_rf_decode
    import uart_rf_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              is_write,
    input  logic              bank,
    output reg_sel_e          sel
);
    always_comb begin
        unique case (addr)
            OFF_DATA: sel = bank ? SEL_DLL : (is_write ? SEL_THR : SEL_RBR);
            OFF_IEN:  sel = bank ? SEL_DLM : SEL_IER;
            OFF_ID:   sel = is_write ? SEL_FCR : SEL_IIR;
            OFF_LINE: sel = SEL_LCR;
            OFF_MDMC: sel = SEL_MCR;
            OFF_LSTA: sel = is_write ? SEL_NONE : SEL_LSR;
            OFF_MSTA: sel = is_write ? SEL_NONE : SEL_MSR;
            OFF_SCR:  sel = SEL_SCR;
            default:  sel = SEL_NONE;
        endcase
    end
endmodule

// File: rtl/uart_rf_lsr.sv
module uart_rf_lsr
    import uart_rf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [EVT_W-1:0]  evt_in,
    input  logic              rx_ready,
    input  logic              thr_free,
    input  logic              tx_idle,
    input  logic              fifo_err,
    output logic [DATA_W-1:0] lsr
);
    logic [EVT_W-1:0] held_q;
    logic [EVT_W-1:0] held_now;

    assign held_now = held_q | evt_in;

    always_ff @(posedge clk) begin
        if (!rst_n)   held_q <= '0;
        else if (clr) held_q <= evt_in;
        else          held_q <= held_now;
    end

    assign lsr = {fifo_err, tx_idle, thr_free, held_now, rx_ready};
endmodule

// File: rtl/uart_rf_iid.sv
module uart_rf_iid
    import uart_rf_pkg::*;
(
    input  logic [3:0]        ien,
    input  logic              line_err,
    input  logic              rx_ready,
    input  logic              thr_free,
    input  logic              modem_chg,
    input  logic              fifo_on,
    output logic [DATA_W-1:0] iid
);
    logic [3:0] code;

    always_comb begin
        if (ien[2] && line_err)       code = 4'h6;
        else if (ien[0] && rx_ready)  code = 4'h4;
        else if (ien[1] && thr_free)  code = 4'h2;
        else if (ien[3] && modem_chg) code = 4'h0;
        else                          code = 4'h1;
    end

    assign iid = {{2{fifo_on}}, 2'b00, code};
endmodule

// File: rtl/uart_regfile.sv
module uart_regfile
    import uart_rf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic [7:0]        rx_byte,
    input  logic              rx_ready,
    input  logic              rx_overrun,
    input  logic              rx_parity_err,
    input  logic              rx_frame_err,
    input  logic              rx_break,
    input  logic              tx_hold_empty,
    input  logic              tx_empty,
    input  logic              rx_fifo_err,
    input  logic [7:0]        modem_stat,
    output logic              tx_strobe,
    output logic [7:0]        tx_byte,
    output logic              rx_pop,
    output logic [3:0]        ier_cfg,
    output logic [7:0]        lcr_cfg,
    output logic [7:0]        mcr_cfg,
    output logic [7:0]        fcr_cfg,
    output logic [15:0]       divisor
);
    localparam int BANK_BIT = DATA_W - 1;

    acc_state_e        state_q, state_d;
    reg_sel_e          sel, sel_q;
    logic              rd_go;
    logic [DATA_W-1:0] ier_q, lcr_q, mcr_q, fcr_q, scr_q, thr_q, dll_q, dlm_q;
    logic [DATA_W-1:0] lsr_val, iid_val, rd_mux;

    assign rd_go = rd_en && !wr_en;

    uart_rf_decode i_decode (
        .addr     (addr),
        .is_write (wr_en),
        .bank     (lcr_q[BANK_BIT]),
        .sel      (sel)
    );

    uart_rf_lsr i_lsr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (rd_go && sel == SEL_LSR),
        .evt_in   ({rx_break, rx_frame_err, rx_parity_err, rx_overrun}),
        .rx_ready (rx_ready),
        .thr_free (tx_hold_empty),
        .tx_idle  (tx_empty),
        .fifo_err (rx_fifo_err),
        .lsr      (lsr_val)
    );

    uart_rf_iid i_iid (
        .ien       (ier_q[3:0]),
        .line_err  (|lsr_val[4:1]),
        .rx_ready  (rx_ready),
        .thr_free  (tx_hold_empty),
        .modem_chg (|modem_stat[3:0]),
        .fifo_on   (fcr_q[0]),
        .iid       (iid_val)
    );

    // access tracker: next state
    always_comb begin
        if (wr_en)      state_d = ACC_WRITE;
        else if (rd_en) state_d = ACC_READ;
        else            state_d = ACC_IDLE;
    end

    // access tracker: state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ACC_IDLE;
            sel_q   <= SEL_NONE;
        end else begin
            state_q <= state_d;
            sel_q   <= sel;
        end
    end

    // access tracker: outputs
    always_comb begin
        tx_strobe = 1'b0;
        rx_pop    = 1'b0;
        unique case (state_q)
            ACC_IDLE:  ;
            ACC_READ:  rx_pop    = (sel_q == SEL_RBR);
            ACC_WRITE: tx_strobe = (sel_q == SEL_THR);
            default:   ;
        endcase
    end

    // configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ier_q <= '0; lcr_q <= '0; mcr_q <= '0; fcr_q <= '0;
            scr_q <= '0; thr_q <= '0; dll_q <= '0; dlm_q <= '0;
        end else if (wr_en) begin
            unique case (sel)
                SEL_THR: thr_q <= wdata;
                SEL_IER: ier_q <= {4'b0, wdata[3:0]};
                SEL_FCR: fcr_q <= wdata;
                SEL_LCR: lcr_q <= wdata;
                SEL_MCR: mcr_q <= wdata;
                SEL_SCR: scr_q <= wdata;
                SEL_DLL: dll_q <= wdata;
                SEL_DLM: dlm_q <= wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (sel)
            SEL_RBR: rd_mux = rx_byte;
            SEL_IER: rd_mux = ier_q;
            SEL_IIR: rd_mux = iid_val;
            SEL_LCR: rd_mux = lcr_q;
            SEL_MCR: rd_mux = mcr_q;
            SEL_LSR: rd_mux = lsr_val;
            SEL_MSR: rd_mux = modem_stat;
            SEL_SCR: rd_mux = scr_q;
            SEL_DLL: rd_mux = dll_q;
            SEL_DLM: rd_mux = dlm_q;
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_go) rdata <= rd_mux;
    end

    assign tx_byte = thr_q;
    assign ier_cfg = ier_q[3:0];
    assign lcr_cfg = lcr_q;
    assign mcr_cfg = mcr_q;
    assign fcr_cfg = fcr_q;
    assign divisor = {dlm_q, dll_q};
endmodule

// File: rtl/uart_regfile_chk.sv
module uart_regfile_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [2:0]  addr,
    input logic        wr_en,
    input logic        rd_en,
    input logic [7:0]  wdata,
    input logic [7:0]  rdata,
    input logic        tx_strobe,
    input logic [7:0]  tx_byte,
    input logic        rx_pop,
    input logic [7:0]  lcr_cfg,
    input logic [15:0] divisor
);
    AST_THR_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && addr == 3'd0 && !lcr_cfg[7] |=> tx_strobe && tx_byte == $past(wdata)); // R2
    AST_DIV_LOW_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && addr == 3'd0 && lcr_cfg[7] |=> !tx_strobe && divisor[7:0] == $past(wdata)); // R3
    AST_DIV_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(divisor)); // R3
    AST_POP_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop |-> $past(rd_en && !wr_en && addr == 3'd0 && !lcr_cfg[7])); // R4
    AST_RO_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && (addr == 3'd5 || addr == 3'd6) |=> $stable(lcr_cfg) && $stable(divisor) && !tx_strobe); // R9
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && !wr_en) |=> $stable(rdata)); // R11
    AST_COLLIDE_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && wr_en |=> !rx_pop); // R10
endmodule

bind uart_regfile uart_regfile_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (addr),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .wdata     (wdata),
    .rdata     (rdata),
    .tx_strobe (tx_strobe),
    .tx_byte   (tx_byte),
    .rx_pop    (rx_pop),
    .lcr_cfg   (lcr_cfg),
    .divisor   (divisor)
);

// File: tb/test_uart_regfile.sv
`timescale 1ns/1ps
module test_uart_regfile;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  addr = '0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0]  wdata = '0, rx_byte = '0, modem_stat = '0;
    logic        rx_ready = 0, rx_overrun = 0, rx_parity_err = 0, rx_frame_err = 0;
    logic        rx_break = 0, tx_hold_empty = 0, tx_empty = 0, rx_fifo_err = 0;
    logic [7:0]  rdata, tx_byte, lcr_cfg, mcr_cfg, fcr_cfg;
    logic        tx_strobe, rx_pop;
    logic [3:0]  ier_cfg;
    logic [15:0] divisor;

    int n_checks = 0, n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    uart_regfile i_uart_regfile (.*);

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // each access ends on the falling edge after its rising edge
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; rd_en = 1;
        @(negedge clk); rd_en = 0; d = rdata;
    endtask

    function automatic logic [7:0] exp_iid(logic [3:0] ien, logic err, logic rdy,
                                           logic thre, logic mdm, logic fen);
        logic [3:0] c;
        if (ien[2] && err)       c = 4'h6;
        else if (ien[0] && rdy)  c = 4'h4;
        else if (ien[1] && thre) c = 4'h2;
        else if (ien[3] && mdm)  c = 4'h0;
        else                     c = 4'h1;
        return {fen, fen, 2'b00, c};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1 ier", {12'b0, ier_cfg}, 16'h0);
        check("R1 lcr", {8'b0, lcr_cfg}, 16'h0);
        check("R1 div", divisor, 16'h0);
        check("R1 rdata", {8'b0, rdata}, 16'h0);
        check("R1 strobes", {14'b0, tx_strobe, rx_pop}, 16'h0);
        rd(3'd7, v); check("R1 scratch", {8'b0, v}, 16'h0);

        // R8 scratch sweep, all byte values
        for (int i = 0; i < 256; i++) begin
            wr(3'd7, 8'(i)); rd(3'd7, v);
            check("R8 scratch", {8'b0, v}, 16'(i));
        end
        wr(3'd4, 8'hA5); rd(3'd4, v); check("R8 mcr", {8'b0, v}, 16'hA5);
        check("R8 mcr_cfg", {8'b0, mcr_cfg}, 16'hA5);
        modem_stat = 8'h3C; rd(3'd6, v); check("R8 msr", {8'b0, v}, 16'h3C);
        modem_stat = 8'h00;

        // R2 transmit and interrupt enable in bank 0
        for (int i = 0; i < 256; i += 37) begin
            wr(3'd0, 8'(i));
            check("R2 tx_strobe", {15'b0, tx_strobe}, 16'h1);
            check("R2 tx_byte", {8'b0, tx_byte}, 16'(i));
            @(negedge clk);
            check("R2 strobe one cycle", {15'b0, tx_strobe}, 16'h0);
        end
        wr(3'd1, 8'hFB); rd(3'd1, v);
        check("R2 ier readback", {8'b0, v}, 16'h0B);
        check("R2 ier_cfg", {12'b0, ier_cfg}, 16'h0B);

        // R3 divisor bank sweep
        wr(3'd3, 8'h83);
        check("R8 lcr", {8'b0, lcr_cfg}, 16'h83);
        for (int i = 0; i < 256; i += 5) begin
            wr(3'd0, 8'(i));
            check("R3 no tx_strobe", {15'b0, tx_strobe}, 16'h0);
            wr(3'd1, 8'(255 - i));
            check("R3 divisor", divisor, 16'((255 - i) * 256 + i));
            rd(3'd0, v); check("R3 dll read", {8'b0, v}, 16'(i));
            check("R4 no pop in bank 1", {15'b0, rx_pop}, 16'h0);
            rd(3'd1, v); check("R3 dlm read", {8'b0, v}, 16'(255 - i));
        end
        check("R3 ier untouched", {12'b0, ier_cfg}, 16'h0B);
        wr(3'd3, 8'h03);
        rd(3'd1, v); check("R3 ier back in bank 0", {8'b0, v}, 16'h0B);
        check("R3 divisor kept", divisor, 16'(0 * 256 + 255));

        // R4 receive pop
        rx_byte = 8'h5E; rd(3'd0, v);
        check("R4 rbr data", {8'b0, v}, 16'h5E);
        check("R4 pop", {15'b0, rx_pop}, 16'h1);
        @(negedge clk);
        check("R4 pop one cycle", {15'b0, rx_pop}, 16'h0);
        for (int a = 1; a < 8; a++) begin
            rd(3'(a), v);
            check("R4 no pop other offset", {15'b0, rx_pop}, 16'h0);
        end

        // R5 line status bit positions, one bit at a time
        for (int b = 0; b < 8; b++) begin
            {rx_fifo_err, tx_empty, tx_hold_empty, rx_break, rx_frame_err,
             rx_parity_err, rx_overrun, rx_ready} = 8'(1 << b);
            rd(3'd5, v);
            check("R5 lsr bit", {8'b0, v}, 16'(1 << b));
            {rx_fifo_err, tx_empty, tx_hold_empty, rx_break, rx_frame_err,
             rx_parity_err, rx_overrun, rx_ready} = 8'h00;
            rd(3'd5, v);
        end

        // R6 sticky events: pulse, read twice
        for (int b = 1; b < 5; b++) begin
            @(negedge clk);
            {rx_break, rx_frame_err, rx_parity_err, rx_overrun} = 4'(1 << (b - 1));
            @(negedge clk);
            {rx_break, rx_frame_err, rx_parity_err, rx_overrun} = 4'h0;
            repeat (3) @(negedge clk);
            rd(3'd5, v); check("R6 sticky held", {8'b0, v}, 16'(1 << b));
            rd(3'd5, v); check("R6 cleared by read", {8'b0, v}, 16'h0);
        end
        rx_ready = 1; rd(3'd5, v); check("R6 data ready live", {8'b0, v}, 16'h01);
        rx_ready = 0; rd(3'd5, v); check("R6 data ready live off", {8'b0, v}, 16'h00);

        // R7 identification priority sweep
        wr(3'd2, 8'h01);
        check("R7 fcr_cfg", {8'b0, fcr_cfg}, 16'h01);
        for (int e = 0; e < 16; e++) begin
            wr(3'd1, 8'(e));
            for (int s = 0; s < 16; s++) begin
                @(negedge clk);
                rx_parity_err = s[0]; rx_ready = s[1]; tx_hold_empty = s[2];
                modem_stat = {7'b0, s[3]};
                rd(3'd2, v);
                check("R7 iid", {8'b0, v},
                      {8'b0, exp_iid(4'(e), s[0], s[1], s[2], s[3], 1'b1)});
                rx_parity_err = 0; rx_ready = 0; tx_hold_empty = 0; modem_stat = 0;
                rd(3'd5, v);
            end
        end
        wr(3'd2, 8'h00); wr(3'd1, 8'h00);
        rd(3'd2, v); check("R7 no source fifo off", {8'b0, v}, 16'h01);

        // R9 writes to status offsets ignored
        wr(3'd3, 8'h1B); wr(3'd7, 8'h66);
        wr(3'd5, 8'hFF);
        check("R9 lcr after write 5", {8'b0, lcr_cfg}, 16'h1B);
        wr(3'd6, 8'hFF);
        check("R9 no tx after write 6", {15'b0, tx_strobe}, 16'h0);
        rd(3'd5, v); check("R9 lsr unchanged", {8'b0, v}, 16'h00);
        rd(3'd7, v); check("R9 scratch unchanged", {8'b0, v}, 16'h66);
        check("R9 divisor unchanged", divisor, 16'h00FF);

        // R10 simultaneous read and write
        rd(3'd7, v);
        @(negedge clk); addr = 3'd0; wdata = 8'h99; wr_en = 1; rd_en = 1;
        @(negedge clk); wr_en = 0; rd_en = 0;
        check("R10 write wins", {15'b0, tx_strobe}, 16'h1);
        check("R10 no pop", {15'b0, rx_pop}, 16'h0);
        check("R10 rdata held", {8'b0, rdata}, 16'h66);

        // R11 rdata holds without a read
        repeat (4) @(negedge clk);
        check("R11 rdata stable", {8'b0, rdata}, 16'h66);

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule